// File: doc/BRIEF.md
# Dual-Hart Load-Reserved / Store-Conditional Reservation Monitor

This block sits between two processor harts and one shared memory. It decides whether each store-conditional succeeds. Each hart presents requests over a valid/ready pair. A request is a load-reserved, a store-conditional, an atomic add or a plain store, in 32-bit word or 64-bit doubleword form. A round-robin arbiter grants one hart per cycle. The granted request is fully resolved in that cycle: the memory read, the reservation lookup and the write all happen there. This prevents the other hart from slipping a write between the check and the store.

Every hart owns one reservation register. The register holds a valid flag, the size-aligned address and the access size. A load-reserved sets the register. A store-conditional always clears it. Any successful write by the other hart to the same aligned doubleword also clears it. A failed store-conditional leaves memory untouched. Each result comes back on a response strobe one cycle after the handshake. Software increment loops built from these primitives on both harts therefore reach exact totals.

Top module: `lrsc_monitor`

## Requirements
- R1: A load-reserved (op code 0) returns memory contents and sets the hart's reservation. The doubleword form (size bit 1) returns all 64 bits. The word form (size bit 0) returns the half selected by address bit 2 (1 = upper half), sign-extended to 64 bits.
- R2: A store-conditional (op code 1) with a matching reservation writes its data and returns 0.
- R3: A store-conditional without a matching reservation returns 1 and leaves memory unchanged.
- R4: A store-conditional consumes the hart's reservation, so a second one without a new load-reserved returns 1.
- R5: Two harts reserving different doublewords can both succeed with their store-conditionals, in either order.
- R6: A store-conditional to an address reserved only by the other hart returns 1. The other hart's reservation survives, and its own store-conditional then returns 0.
- R7: A write by one hart clears the other hart's reservation when both fall in the same aligned doubleword. Writes here are a plain store (op code 3, response 0), an atomic add or a successful store-conditional. A write to a different doubleword leaves that reservation valid.
- R8: A reservation matches only on equal size and equal address aligned to that size (low 3 bits ignored for doublewords, low 2 for words). A new load-reserved replaces the hart's earlier reservation.
- R9: An atomic add (op code 2) returns the old value, with the word form sign-extended. It writes old plus operand, wrapping at 32 bits in the word form.
- R10: The response strobe of the requesting hart rises in the cycle after the handshake. At most one hart is granted per cycle, and two harts requesting together are served in consecutive cycles.
- R11: After reset all reservations are invalid, the memory reads zero, and no response or grant is active.
- R12: Concurrent increment loops on one doubleword reach the exact sum of all increments. This holds for two load-reserved/store-conditional loops, and for one such loop running against atomic adds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NHARTS | Request present, one bit per hart |
| req_ready | output | NHARTS | Request granted this cycle, one bit per hart |
| req_op | input | NHARTS x 2 | Operation per hart: 0 load-reserved, 1 store-conditional, 2 atomic add, 3 store |
| req_dw | input | NHARTS | Size per hart: 1 doubleword, 0 word |
| req_addr | input | NHARTS x ADDR_W | Byte address per hart |
| req_wdata | input | NHARTS x 64 | Store data or add operand per hart (low 32 bits for words) |
| rsp_valid | output | NHARTS | Response strobe per hart |
| rsp_data | output | 64 | Loaded or old value, store-conditional status, or zero for stores |

## Verification
The hardest case to reach is a reservation killed by the other hart. This needs the other hart's write to the same doubleword to fall between a load-reserved and the matching store-conditional. The stimulus also needs word-granular variants where the two harts touch different halves of one doubleword. Directed sequences place those writes explicitly between the two operations of one hart. Forked increment loops on both harts then let the arbiter interleave load-reserved and store-conditional requests on its own, so reservation loss and retries occur naturally, and only the final exact sum is checked.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
    typedef enum logic [1:0] {
        OP_LR     = 2'd0,
        OP_SC     = 2'd1,
        OP_AMOADD = 2'd2,
        OP_STORE  = 2'd3
    } op_e;
endpackage

// File: rtl/lrsc_rr_arbiter.sv
module lrsc_rr_arbiter #(
    parameter int N = 2,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx,
    output logic          any
);
    typedef struct packed {
        logic [IW-1:0] last;
    } arb_t;

    arb_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        gnt     = '0;
        gnt_idx = s_q.last;
        any     = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int c;
            c = (int'(s_q.last) + k) % N;
            if (!any && req[c]) begin
                any     = 1'b1;
                gnt[c]  = 1'b1;
                gnt_idx = IW'(c);
            end
        end
        if (any) s_d.last = gnt_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{last: IW'(N - 1)};
        else        s_q <= s_d;
    end

    p_grant_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    p_grant_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
    p_rr_rotates_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(req) > 1 && $past($countones(req) > 1) && $past(any))
        |-> (gnt != $past(gnt)));
endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv
    import lrsc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  op_e               op,
    input  logic              is_dw,
    input  logic [ADDR_W-1:0] addr_al,
    input  logic              wr_en,
    input  logic              wr_other,
    input  logic [ADDR_W-4:0] wr_line,
    output logic              match
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic              dw;
    } resv_t;

    resv_t s_d, s_q;
    logic  hit_line;

    always_comb begin
        s_d      = s_q;
        match    = s_q.valid && (s_q.addr == addr_al) && (s_q.dw == is_dw);
        hit_line = (s_q.addr[ADDR_W-1:3] == wr_line);
        if (acc && op == OP_LR) begin
            s_d.valid = 1'b1;
            s_d.addr  = addr_al;
            s_d.dw    = is_dw;
        end else if (acc && op == OP_SC) begin
            s_d.valid = 1'b0;
        end else if (wr_en && wr_other && hit_line) begin
            s_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    p_lr_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op == OP_LR) |=> s_q.valid);
    p_sc_consumes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op == OP_SC) |=> !s_q.valid);
    p_foreign_write_kills_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_other && s_q.valid && s_q.addr[ADDR_W-1:3] == wr_line) |=> !s_q.valid);
endmodule

// File: rtl/lrsc_mem.sv
module lrsc_mem #(
    parameter int IDX_W = 8,
    localparam int WORDS = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    output logic [63:0]      rdata,
    input  logic             we,
    input  logic [1:0]       half_en,
    input  logic [63:0]      wdata
);
    logic [63:0] mem_q [WORDS];

    assign rdata = mem_q[idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else if (we) begin
            if (half_en[0]) mem_q[idx][31:0]  <= wdata[31:0];
            if (half_en[1]) mem_q[idx][63:32] <= wdata[63:32];
        end
    end

    p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> (mem_q[$past(idx)] == $past(rdata)));
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
    import lrsc_pkg::*;
#(
    parameter int NHARTS    = 2,
    parameter int ADDR_W    = 12,
    parameter int MEM_WORDS = 256
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NHARTS-1:0]             req_valid,
    output logic [NHARTS-1:0]             req_ready,
    input  logic [NHARTS-1:0][1:0]        req_op,
    input  logic [NHARTS-1:0]             req_dw,
    input  logic [NHARTS-1:0][ADDR_W-1:0] req_addr,
    input  logic [NHARTS-1:0][63:0]       req_wdata,
    output logic [NHARTS-1:0]             rsp_valid,
    output logic [63:0]                   rsp_data
);
    localparam int IDX_W  = $clog2(MEM_WORDS);
    localparam int HW     = (NHARTS > 1) ? $clog2(NHARTS) : 1;
    localparam int LINE_W = ADDR_W - 3;

    typedef struct packed {
        logic [NHARTS-1:0] valid;
        logic [63:0]       data;
    } rsp_t;

    rsp_t s_d, s_q;

    logic [NHARTS-1:0] gnt, match;
    logic [HW-1:0]     sel;
    logic              any;
    op_e               op;
    logic              dw, hi, sc_ok, mem_we;
    logic [ADDR_W-1:0] addr_al;
    logic [63:0]       wd, rd, ld, mem_wd;
    logic [31:0]       rd32, sum32;
    logic [1:0]        half_en;

    lrsc_rr_arbiter #(.N(NHARTS)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(req_valid),
        .gnt(gnt), .gnt_idx(sel), .any(any)
    );

    lrsc_mem #(.IDX_W(IDX_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .idx(addr_al[3 +: IDX_W]), .rdata(rd),
        .we(mem_we), .half_en(half_en), .wdata(mem_wd)
    );

    for (genvar h = 0; h < NHARTS; h++) begin : g_resv
        lrsc_resv #(.ADDR_W(ADDR_W)) u_resv (
            .clk(clk), .rst_n(rst_n), .acc(gnt[h]), .op(op), .is_dw(dw),
            .addr_al(addr_al), .wr_en(mem_we), .wr_other(sel != HW'(h)),
            .wr_line(addr_al[ADDR_W-1:3]), .match(match[h])
        );
    end

    assign req_ready = gnt;

    always_comb begin
        op      = op_e'(req_op[sel]);
        dw      = req_dw[sel];
        wd      = req_wdata[sel];
        addr_al = req_addr[sel] & (dw ? ~ADDR_W'(7) : ~ADDR_W'(3));
        hi      = addr_al[2];
        rd32    = hi ? rd[63:32] : rd[31:0];
        ld      = dw ? rd : {{32{rd32[31]}}, rd32};
        sum32   = rd32 + wd[31:0];
        sc_ok   = match[sel];
        half_en = dw ? 2'b11 : (hi ? 2'b10 : 2'b01);
        mem_we  = 1'b0;
        mem_wd  = dw ? wd : {wd[31:0], wd[31:0]};
        s_d     = s_q;
        s_d.valid = gnt;
        s_d.data  = '0;
        if (any) begin
            unique case (op)
                OP_LR: s_d.data = ld;
                OP_SC: begin
                    mem_we   = sc_ok;
                    s_d.data = {63'd0, !sc_ok};
                end
                OP_AMOADD: begin
                    mem_we   = 1'b1;
                    mem_wd   = dw ? (rd + wd) : {sum32, sum32};
                    s_d.data = ld;
                end
                OP_STORE: mem_we = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid = s_q.valid;
    assign rsp_data  = s_q.data;

    p_one_response_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid));
    p_sc_status_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (any && op == OP_SC) |=> (rsp_data[63:1] == '0));

    if (LINE_W < IDX_W) begin : g_bad_cfg
        initial $error("ADDR_W too small for MEM_WORDS");
    end
endmodule

// File: tb/sim_lrsc_monitor.sv
module sim_lrsc_monitor;
    import lrsc_pkg::*;

    localparam int CLK_P = 10;

    typedef struct {
        bit          chk;
        logic [63:0] data;
        string       tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       req_valid = '0;
    logic [1:0]       req_ready;
    logic [1:0][1:0]  req_op = '0;
    logic [1:0]       req_dw = '0;
    logic [1:0][11:0] req_addr = '0;
    logic [1:0][63:0] req_wdata = '0;
    logic [1:0]       rsp_valid;
    logic [63:0]      rsp_data;

    int   checks = 0, failures = 0, cyc = 0;
    exp_t q0[$], q1[$];

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lrsc_monitor u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_dw(req_dw), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            for (int h = 0; h < 2; h++) begin
                if (rsp_valid[h]) begin
                    exp_t e;
                    if ((h == 0 && q0.size() == 0) || (h == 1 && q1.size() == 0)) begin
                        check(1'b0, "R10 unexpected response", 64'(h), 64'd0);
                    end else begin
                        e = (h == 0) ? q0.pop_front() : q1.pop_front();
                        if (e.chk) check(rsp_data === e.data, e.tag, rsp_data, e.data);
                    end
                end
            end
        end
    end

    task automatic do_req(input int h, input op_e op, input bit dw, input logic [11:0] a,
                          input logic [63:0] wd, input bit chk, input logic [63:0] exp,
                          input string tag, output logic [63:0] got);
        exp_t e;
        bit r;
        e.chk = chk; e.data = exp; e.tag = tag;
        if (h == 0) q0.push_back(e); else q1.push_back(e);
        @(negedge clk);
        req_op[h] = op; req_dw[h] = dw; req_addr[h] = a; req_wdata[h] = wd;
        req_valid[h] = 1'b1;
        forever begin
            #(CLK_P/2 - 1);
            r = req_ready[h];
            @(posedge clk);
            if (r) break;
        end
        @(negedge clk);
        req_valid[h] = 1'b0;
        got = rsp_data;
    endtask

    task automatic t(input int h, input op_e op, input bit dw, input logic [11:0] a,
                     input logic [63:0] wd, input logic [63:0] exp, input string tag);
        logic [63:0] g;
        do_req(h, op, dw, a, wd, 1'b1, exp, tag, g);
    endtask

    task automatic lrsc_inc(input int h, input logic [11:0] a, input int n);
        logic [63:0] v, s;
        for (int i = 0; i < n; i++) begin
            do begin
                do_req(h, OP_LR, 1'b1, a, 64'd0, 1'b0, 64'd0, "", v);
                do_req(h, OP_SC, 1'b1, a, v + 64'd1, 1'b0, 64'd0, "", s);
            end while (s != 64'd0);
        end
    endtask

    task automatic amo_inc(input int h, input logic [11:0] a, input int n);
        logic [63:0] v;
        for (int i = 0; i < n; i++) do_req(h, OP_AMOADD, 1'b1, a, 64'd1, 1'b0, 64'd0, "", v);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int c0, c1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 2'b00 && req_ready == 2'b00, "R11 idle after reset", {62'd0, rsp_valid}, 64'd0);
        t(0, OP_SC, 1, 12'h100, 64'd9, 64'd1, "R11 SC after reset fails");
        t(0, OP_LR, 1, 12'h100, 64'd0, 64'd0, "R11 memory zero after reset");
        t(0, OP_STORE, 1, 12'h100, 64'd5, 64'd0, "R7 store response");
        t(1, OP_STORE, 1, 12'h200, 64'd5, 64'd0, "R7 store response");
        t(0, OP_LR, 1, 12'h100, 64'd0, 64'd5, "R1 LR doubleword");
        t(1, OP_LR, 1, 12'h200, 64'd0, 64'd5, "R1 LR doubleword");
        t(0, OP_SC, 1, 12'h100, 64'd6, 64'd0, "R2 SC success");
        t(0, OP_SC, 1, 12'h100, 64'd0, 64'd1, "R4 second SC fails");
        t(0, OP_LR, 1, 12'h100, 64'd0, 64'd6, "R3 memory unchanged after failed SC");
        t(0, OP_SC, 1, 12'h200, 64'd7, 64'd1, "R6 SC on other hart's line fails");
        t(1, OP_SC, 1, 12'h200, 64'd7, 64'd0, "R6 owner SC still succeeds");
        t(1, OP_LR, 1, 12'h200, 64'd0, 64'd7, "R6 owner data written");
        t(0, OP_LR, 1, 12'h100, 64'd0, 64'd6, "R5 LR hart0");
        t(1, OP_SC, 1, 12'h200, 64'd8, 64'd0, "R5 hart1 SC first");
        t(0, OP_SC, 1, 12'h100, 64'd9, 64'd0, "R5 hart0 SC second");
        t(0, OP_LR, 1, 12'h100, 64'd0, 64'd9, "R5 value after SC");
        t(1, OP_STORE, 1, 12'h100, 64'd11, 64'd0, "R7 foreign store");
        t(0, OP_SC, 1, 12'h100, 64'd1, 64'd1, "R7 store kills reservation");
        t(0, OP_LR, 1, 12'h100, 64'd0, 64'd11, "R7 LR again");
        t(1, OP_AMOADD, 1, 12'h100, 64'd1, 64'd11, "R9 AMO returns old");
        t(0, OP_SC, 1, 12'h100, 64'd1, 64'd1, "R7 AMO kills reservation");
        t(0, OP_LR, 1, 12'h100, 64'd0, 64'd12, "R9 AMO sum written");
        t(0, OP_LR, 0, 12'h100, 64'd0, 64'd12, "R1 LR word low half");
        t(1, OP_STORE, 0, 12'h104, 64'd3, 64'd0, "R7 word store other half");
        t(0, OP_SC, 0, 12'h100, 64'd1, 64'd1, "R7 same doubleword kill");
        t(0, OP_LR, 1, 12'h100, 64'd0, 64'h0000_0003_0000_000C, "R1 both halves");
        t(1, OP_STORE, 1, 12'h200, 64'd1, 64'd0, "R7 unrelated store");
        t(0, OP_SC, 1, 12'h100, 64'h40, 64'd0, "R7 unrelated line keeps reservation");
        t(1, OP_STORE, 0, 12'h300, 64'h8000_0001, 64'd0, "R1 word store");
        t(0, OP_LR, 0, 12'h300, 64'd0, 64'hFFFF_FFFF_8000_0001, "R1 sign extension");
        t(0, OP_LR, 0, 12'h304, 64'd0, 64'd0, "R1 upper half");
        t(0, OP_LR, 1, 12'h300, 64'd0, 64'h8000_0001, "R8 LR dw");
        t(0, OP_SC, 0, 12'h300, 64'd5, 64'd1, "R8 size mismatch fails");
        t(0, OP_LR, 1, 12'h300, 64'd0, 64'h8000_0001, "R8 LR dw again");
        t(0, OP_LR, 1, 12'h200, 64'd0, 64'd1, "R8 LR replaces");
        t(0, OP_SC, 1, 12'h300, 64'd5, 64'd1, "R8 old reservation gone");
        t(0, OP_LR, 1, 12'h305, 64'd0, 64'h8000_0001, "R8 unaligned LR");
        t(0, OP_SC, 1, 12'h301, 64'd4, 64'd0, "R8 aligned match");
        t(1, OP_LR, 1, 12'h300, 64'd0, 64'd4, "R8 aligned write");
        t(1, OP_STORE, 0, 12'h400, 64'hFFFF_FFFF, 64'd0, "R9 word store");
        t(1, OP_AMOADD, 0, 12'h400, 64'd2, 64'hFFFF_FFFF_FFFF_FFFF, "R9 word AMO old");
        t(1, OP_LR, 0, 12'h400, 64'd0, 64'd1, "R9 word wrap");
        t(1, OP_LR, 0, 12'h404, 64'd0, 64'd0, "R9 upper half untouched");
        fork
            begin t(0, OP_STORE, 1, 12'h600, 64'd1, 64'd0, "R10 concurrent"); c0 = cyc; end
            begin t(1, OP_STORE, 1, 12'h608, 64'd2, 64'd0, "R10 concurrent"); c1 = cyc; end
        join
        check((c0 - c1 == 1) || (c1 - c0 == 1), "R10 consecutive grants", 64'(c0), 64'(c1));
        fork
            lrsc_inc(0, 12'h500, 20);
            lrsc_inc(1, 12'h500, 20);
        join
        t(0, OP_LR, 1, 12'h500, 64'd0, 64'd40, "R12 two LR/SC loops");
        fork
            amo_inc(0, 12'h500, 20);
            lrsc_inc(1, 12'h500, 20);
        join
        t(1, OP_LR, 1, 12'h500, 64'd0, 64'd80, "R12 LR/SC with AMO");
        repeat (3) @(negedge clk);
        check(q0.size() == 0 && q1.size() == 0, "R10 all responses seen",
              64'(q0.size() + q1.size()), 64'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule